// File: doc/BRIEF.md
# Audio Clock Status and Notification Register Unit

This block is the clocking control and status window of an audio streaming interface. A host reaches it over a quadlet-wide register bus. Each bus request is one beat, and the bus offers quadlet read, block-read beat, quadlet write and 64-bit compare-and-swap. The unit holds the host's ownership address, the sample clock selection and the stream enable. It shows the live lock state of eleven clock sources and the current clock lock and nominal rate. It also keeps sticky slip flags, one per source.

Events come from three places: configuration-change pulses, lock changes and accepted clock-select writes. Each event cycle replaces the notification word. While an owner is registered, the same event bits are also pushed to the owner's address as a request on an outgoing valid/ready channel. The request FSM has two states. In `NT_IDLE` nothing is pending. In `NT_SEND` a word is on the channel. Its transitions are:
- *issue*: `NT_IDLE` to `NT_SEND`, when events occur with an owner set.
- *chain*: `NT_SEND` to `NT_SEND`, on a handshake when events have been merged while waiting.
- *drain*: `NT_SEND` to `NT_IDLE`, on a handshake with nothing merged.
- *abort*: any state to `NT_IDLE`, on bus reset.

Register map (byte offsets; index = offset/4):

| Offset | Register |
|---|---|
| 0x00 | owner bits 63:32 |
| 0x04 | owner bits 31:0 |
| 0x08 | notification word, read-only |
| 0x0C | clock select |
| 0x10 | stream enable |
| 0x14 | clock status, read-only |
| 0x18 | extended source status, read-only |

Bus op codes: 0 quadlet read, 1 block-read beat, 2 quadlet write, 3 compare-and-swap.

Top module: `clkstat_regs`

## Requirements
- R1: After reset the owner holds 0xFFFF_0000_0000_0000, which is the idle (no owner) value. Offset 0x00 reads bits 63:32 and offset 0x04 reads bits 31:0.
- R2: A compare-and-swap at offset 0x00 returns the old 64-bit owner on `rsp_rdata_o`. The owner takes `req_wdata_i` only when `req_cmp_i` equals the old owner; otherwise it is unchanged.
- R3: The following return `rsp_err_o`=1 and change no register: a quadlet write to the owner, notification, status or extended status register; a compare-and-swap at any offset other than 0x00; an access with address bits 1:0 non-zero; an offset above 0x18.
- R4: A `bus_rst_i` pulse sets the owner back to its idle value, clears stream enable and drops any pending notification request.
- R5: A write to 0x0C stores bits 7:0 (source code) and 15:8 (rate code), which read back at the same positions. Every such write raises event bit 5.
- R6: A write of any non-zero value to 0x10 sets `stream_en_o` and reads back 1. Writing zero clears both.
- R7: Offset 0x14 reads the live current lock in bit 0 and the live rate code in bits 15:8.
- R8: Event sources and their bits in the notification word:
  - `rx_cfg_i` sets bit 0 and `tx_cfg_i` sets bit 1.
  - A change of `cur_lock_i` sets bit 4.
  - Offset 0x18 bits 10:0 show `src_lock_i` live, and any change of `src_lock_i` sets bit 6.
- R9: Offset 0x18 bits 26:16 are sticky slip flags, set by `src_slip_i` pulses. A quadlet read of 0x18 returns them and then clears them. A block-read beat does not clear them. A pulse in the same cycle as a clearing read leaves its flag set.
- R10: In any cycle with at least one event, the notification register at 0x08 is replaced by exactly that cycle's event bits.
- R11: When events occur and the owner is not idle, `ntf_valid_o` rises with `ntf_addr_o` = owner and `ntf_word_o` = the event bits. Both are held until `ntf_ready_i`. Events arriving meanwhile are ORed into the next word, which is issued right after the handshake.
- R12: Every request gets `rsp_valid_o` exactly one cycle later. The read data reflects the state before the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_rst_i | input | 1 | Bus reset pulse |
| req_valid_i | input | 1 | Request beat present |
| req_op_i | input | 2 | Op code (0 RDQ, 1 RDB, 2 WRQ, 3 CAS) |
| req_addr_i | input | ADDR_W | Byte offset |
| req_wdata_i | input | 64 | Write data (bits 31:0) or CAS swap value |
| req_cmp_i | input | 64 | CAS compare value |
| rsp_valid_o | output | 1 | Response beat |
| rsp_err_o | output | 1 | Error response |
| rsp_rdata_o | output | 64 | Read quadlet in 31:0, or old owner for CAS |
| src_lock_i | input | N_SRC | Per-source lock levels |
| src_slip_i | input | N_SRC | Per-source slip pulses |
| cur_lock_i | input | 1 | Current source locked |
| cur_rate_i | input | RATE_W | Measured nominal rate code |
| rx_cfg_i | input | 1 | Receive configuration changed pulse |
| tx_cfg_i | input | 1 | Transmit configuration changed pulse |
| stream_en_o | output | 1 | Streaming enabled |
| ntf_valid_o | output | 1 | Notification request valid |
| ntf_ready_i | input | 1 | Notification request accepted |
| ntf_addr_o | output | 64 | Destination (owner) address |
| ntf_word_o | output | 32 | Event word |

## Verification
The bench aims at the slip-clear race:
- A design that lets a clearing read win would lose a slip that arrived in the same cycle as the read.
- A design that clears on block reads would hide slips from a later quadlet read.

It stalls the notification channel and injects an event while stalled. An implementation without merging would drop that event; one that overwrote the pending word would change data under a valid. Compare-and-swap is driven with both a wrong and a right compare value, to catch an owner that updates unconditionally. Writes to read-only, unaligned and out-of-map offsets are checked for error and for unchanged state. A bus reset is applied while streaming, to catch an enable or owner that survives it.

// File: rtl/clkstat_pkg.sv
package clkstat_pkg;

    typedef enum logic [1:0] {
        OP_RDQ = 2'd0,
        OP_RDB = 2'd1,
        OP_WRQ = 2'd2,
        OP_CAS = 2'd3
    } bus_op_e;

    typedef enum logic {
        NT_IDLE = 1'b0,
        NT_SEND = 1'b1
    } ntf_state_e;

    // register indices (byte offset / 4)
    localparam int unsigned RI_OWN_HI = 0;
    localparam int unsigned RI_OWN_LO = 1;
    localparam int unsigned RI_NOTE   = 2;
    localparam int unsigned RI_CSEL   = 3;
    localparam int unsigned RI_ENA    = 4;
    localparam int unsigned RI_STAT   = 5;
    localparam int unsigned RI_XSTAT  = 6;
    localparam int unsigned RI_COUNT  = 7;

    localparam logic [63:0] OWNER_IDLE = 64'hFFFF_0000_0000_0000;

    // event bit positions in the notification word
    localparam int unsigned EV_RXCFG  = 0;
    localparam int unsigned EV_TXCFG  = 1;
    localparam int unsigned EV_LOCK   = 4;
    localparam int unsigned EV_CLKACC = 5;
    localparam int unsigned EV_XSTAT  = 6;
    localparam int unsigned EV_W      = 7;

    localparam int unsigned SLIP_LSB  = 16;

endpackage

// File: rtl/clkstat_decode.sv
module clkstat_decode
    import clkstat_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              req_valid,
    input  bus_op_e           op,
    input  logic [ADDR_W-1:0] addr,
    output logic              rd_ok,
    output logic              wr_ok,
    output logic              cas_ok,
    output logic              err,
    output logic [ADDR_W-3:0] idx
);
    localparam int unsigned IW = ADDR_W - 2;

    logic in_map;

    always_comb begin
        idx    = addr[ADDR_W-1:2];
        in_map = ({{(32-IW){1'b0}}, idx} < RI_COUNT);
        rd_ok  = 1'b0;
        wr_ok  = 1'b0;
        cas_ok = 1'b0;
        if (req_valid && (addr[1:0] == 2'b00) && in_map) begin
            unique case (op)
                OP_RDQ, OP_RDB: rd_ok  = 1'b1;
                OP_WRQ:         wr_ok  = (idx == IW'(RI_CSEL)) || (idx == IW'(RI_ENA));
                OP_CAS:         cas_ok = (idx == IW'(RI_OWN_HI));
                default:        ;
            endcase
        end
        err = req_valid && !(rd_ok || wr_ok || cas_ok);
    end

endmodule

// File: rtl/clkstat_slip.sv
module clkstat_slip
    import clkstat_pkg::*;
#(
    parameter int unsigned N_SRC = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] slip_pulse,
    input  logic             clr,
    output logic [N_SRC-1:0] slip_q
);
    for (genvar g = 0; g < N_SRC; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)                slip_q[g] <= 1'b0;
            else if (slip_pulse[g]) slip_q[g] <= 1'b1;
            else if (clr)           slip_q[g] <= 1'b0;
        end

        // a clearing read with no new slip leaves the flag clear
        assert_slip_clear_R9: assert property (@(posedge clk) disable iff (rst)
            (clr && !slip_pulse[g]) |=> !slip_q[g]);
        // a slip pulse always survives into the next cycle, even against a clear
        assert_slip_wins_R9: assert property (@(posedge clk) disable iff (rst)
            slip_pulse[g] |=> slip_q[g]);
    end

endmodule

// File: rtl/clkstat_notify.sv
module clkstat_notify
    import clkstat_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_rst,
    input  logic [EV_W-1:0] evt,
    input  logic [63:0]     owner,
    input  logic            ready,
    output logic            valid,
    output logic [63:0]     addr,
    output logic [31:0]     word
);
    ntf_state_e      st, st_nxt;
    logic            load;
    logic            owner_set;
    logic [EV_W-1:0] acc;

    assign owner_set = (owner != OWNER_IDLE);

    always_comb begin
        st_nxt = st;
        load   = 1'b0;
        unique case (st)
            NT_IDLE: begin
                if ((|evt) && owner_set) begin
                    st_nxt = NT_SEND;          // issue
                    load   = 1'b1;
                end
            end
            NT_SEND: begin
                if (ready) begin
                    if (((|acc) || (|evt)) && owner_set) load = 1'b1;   // chain
                    else                                  st_nxt = NT_IDLE; // drain
                end
            end
            default: st_nxt = NT_IDLE;
        endcase
        if (bus_rst) begin                     // abort
            st_nxt = NT_IDLE;
            load   = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) st <= NT_IDLE;
        else     st <= st_nxt;
    end

    // output and merge registers
    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            addr <= '0;
            word <= '0;
        end else if (bus_rst) begin
            acc <= '0;
        end else if (load) begin
            word <= 32'(acc | evt);
            addr <= owner;
            acc  <= '0;
        end else if (st == NT_SEND) begin
            if (ready) acc <= '0;
            else       acc <= acc | evt;
        end
    end

    assign valid = (st == NT_SEND);

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready && !bus_rst) |=> (valid && $stable(word) && $stable(addr)));
    assert_owner_R11: assert property (@(posedge clk) disable iff (rst)
        valid |-> (addr != OWNER_IDLE));
    assert_abort_R4: assert property (@(posedge clk) disable iff (rst)
        bus_rst |=> !valid);

endmodule

// File: rtl/clkstat_regs.sv
module clkstat_regs
    import clkstat_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned N_SRC  = 11,
    parameter int unsigned RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rst_i,
    input  logic              req_valid_i,
    input  logic [1:0]        req_op_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [63:0]       req_wdata_i,
    input  logic [63:0]       req_cmp_i,
    output logic              rsp_valid_o,
    output logic              rsp_err_o,
    output logic [63:0]       rsp_rdata_o,
    input  logic [N_SRC-1:0]  src_lock_i,
    input  logic [N_SRC-1:0]  src_slip_i,
    input  logic              cur_lock_i,
    input  logic [RATE_W-1:0] cur_rate_i,
    input  logic              rx_cfg_i,
    input  logic              tx_cfg_i,
    output logic              stream_en_o,
    output logic              ntf_valid_o,
    input  logic              ntf_ready_i,
    output logic [63:0]       ntf_addr_o,
    output logic [31:0]       ntf_word_o
);
    localparam int unsigned IW     = ADDR_W - 2;
    localparam int unsigned CSEL_W = 16;

    bus_op_e           op;
    logic              rd_ok, wr_ok, cas_ok, dec_err;
    logic [IW-1:0]     idx;
    logic [63:0]       owner_q;
    logic              en_q;
    logic [CSEL_W-1:0] csel_q;
    logic [EV_W-1:0]   note_q;
    logic [N_SRC-1:0]  prev_src;
    logic              prev_cur;
    logic [N_SRC-1:0]  slip_q;
    logic              csel_wr, ena_wr, slip_clr;
    logic [EV_W-1:0]   evt;
    logic [31:0]       rd_word, stat_w, xstat_w;

    assign op = bus_op_e'(req_op_i);

    clkstat_decode #(.ADDR_W(ADDR_W)) u_dec (
        .req_valid (req_valid_i),
        .op        (op),
        .addr      (req_addr_i),
        .rd_ok     (rd_ok),
        .wr_ok     (wr_ok),
        .cas_ok    (cas_ok),
        .err       (dec_err),
        .idx       (idx)
    );

    assign csel_wr  = wr_ok && (idx == IW'(RI_CSEL));
    assign ena_wr   = wr_ok && (idx == IW'(RI_ENA));
    assign slip_clr = rd_ok && (op == OP_RDQ) && (idx == IW'(RI_XSTAT));

    clkstat_slip #(.N_SRC(N_SRC)) u_slip (
        .clk        (clk),
        .rst        (rst),
        .slip_pulse (src_slip_i),
        .clr        (slip_clr),
        .slip_q     (slip_q)
    );

    always_comb begin
        evt            = '0;
        evt[EV_RXCFG]  = rx_cfg_i;
        evt[EV_TXCFG]  = tx_cfg_i;
        evt[EV_LOCK]   = (cur_lock_i != prev_cur);
        evt[EV_CLKACC] = csel_wr;
        evt[EV_XSTAT]  = (src_lock_i != prev_src);
    end

    always_comb begin
        stat_w                    = '0;
        stat_w[0]                 = cur_lock_i;
        stat_w[8 +: RATE_W]       = cur_rate_i;
        xstat_w                   = '0;
        xstat_w[N_SRC-1:0]        = src_lock_i;
        xstat_w[SLIP_LSB +: N_SRC] = slip_q;
        unique case (idx)
            IW'(RI_OWN_HI): rd_word = owner_q[63:32];
            IW'(RI_OWN_LO): rd_word = owner_q[31:0];
            IW'(RI_NOTE):   rd_word = 32'(note_q);
            IW'(RI_CSEL):   rd_word = 32'(csel_q);
            IW'(RI_ENA):    rd_word = {31'b0, en_q};
            IW'(RI_STAT):   rd_word = stat_w;
            IW'(RI_XSTAT):  rd_word = xstat_w;
            default:        rd_word = '0;
        endcase
    end

    // edge history for change events; follows the inputs during reset
    always_ff @(posedge clk) begin
        prev_src <= src_lock_i;
        prev_cur <= cur_lock_i;
    end

    always_ff @(posedge clk) begin
        if (rst || bus_rst_i)                      owner_q <= OWNER_IDLE;
        else if (cas_ok && req_cmp_i == owner_q)   owner_q <= req_wdata_i;
    end

    always_ff @(posedge clk) begin
        if (rst || bus_rst_i) en_q <= 1'b0;
        else if (ena_wr)      en_q <= |req_wdata_i[31:0];
    end

    always_ff @(posedge clk) begin
        if (rst)          csel_q <= '0;
        else if (csel_wr) csel_q <= req_wdata_i[CSEL_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)       note_q <= '0;
        else if (|evt) note_q <= evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_o <= 1'b0;
            rsp_err_o   <= 1'b0;
            rsp_rdata_o <= '0;
        end else begin
            rsp_valid_o <= req_valid_i;
            rsp_err_o   <= dec_err;
            if (cas_ok)     rsp_rdata_o <= owner_q;
            else if (rd_ok) rsp_rdata_o <= {32'b0, rd_word};
            else            rsp_rdata_o <= '0;
        end
    end

    assign stream_en_o = en_q;

    clkstat_notify u_ntf (
        .clk     (clk),
        .rst     (rst),
        .bus_rst (bus_rst_i),
        .evt     (evt),
        .owner   (owner_q),
        .ready   (ntf_ready_i),
        .valid   (ntf_valid_o),
        .addr    (ntf_addr_o),
        .word    (ntf_word_o)
    );

    assert_rsp_next_R12: assert property (@(posedge clk) disable iff (rst)
        req_valid_i |=> rsp_valid_o);
    assert_owner_wr_err_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && req_op_i == 2'd2 && req_addr_i == '0 && !bus_rst_i)
            |=> (rsp_err_o && $stable(owner_q)));
    assert_busrst_R4: assert property (@(posedge clk) disable iff (rst)
        bus_rst_i |=> (!stream_en_o && owner_q == OWNER_IDLE));
    assert_err_no_data_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_err_o |-> (rsp_rdata_o == '0));

endmodule

// File: tb/tb_clkstat_regs.sv
module tb_clkstat_regs;
    localparam logic [63:0] IDLE = 64'hFFFF_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_rst = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = '0;
    logic [7:0]  req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic [63:0] req_cmp = '0;
    logic        rsp_valid, rsp_err;
    logic [63:0] rsp_rdata;
    logic [10:0] src_lock = '0;
    logic [10:0] src_slip = '0;
    logic        cur_lock = 1'b0;
    logic [7:0]  cur_rate = 8'h0a;
    logic        rx_cfg = 1'b0, tx_cfg = 1'b0;
    logic        stream_en, ntf_valid;
    logic        ntf_ready = 1'b0;
    logic [63:0] ntf_addr;
    logic [31:0] ntf_word;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    clkstat_regs dut (
        .clk(clk), .rst(rst), .bus_rst_i(bus_rst),
        .req_valid_i(req_valid), .req_op_i(req_op), .req_addr_i(req_addr),
        .req_wdata_i(req_wdata), .req_cmp_i(req_cmp),
        .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
        .src_lock_i(src_lock), .src_slip_i(src_slip),
        .cur_lock_i(cur_lock), .cur_rate_i(cur_rate),
        .rx_cfg_i(rx_cfg), .tx_cfg_i(tx_cfg),
        .stream_en_o(stream_en), .ntf_valid_o(ntf_valid), .ntf_ready_i(ntf_ready),
        .ntf_addr_o(ntf_addr), .ntf_word_o(ntf_word)
    );

    // ---------------- behavioural reference model ----------------
    logic [63:0] m_owner, m_na, m_rd;
    logic        m_en, m_st, m_rv, m_re;
    logic [15:0] m_csel;
    logic [6:0]  m_note, m_acc, ev;
    logic [10:0] m_slip, m_psrc;
    logic        m_pcur;

    function automatic logic [31:0] m_read(int i);
        case (i)
            0: return m_owner[63:32];
            1: return m_owner[31:0];
            2: return {25'b0, m_note};
            3: return {16'b0, m_csel};
            4: return {31'b0, m_en};
            5: return {16'b0, cur_rate, 7'b0, cur_lock};
            6: return {5'b0, m_slip, 5'b0, src_lock};
            default: return 32'b0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_owner = IDLE; m_en = 0; m_csel = 0; m_note = 0; m_slip = 0;
            m_pcur = cur_lock; m_psrc = src_lock; m_st = 0; m_acc = 0;
            m_rv = 0; m_re = 0; m_rd = 0; m_na = 0;
        end else begin
            int i;
            bit e, csw, enw, clr, swap;
            logic [63:0] rdat;
            i = int'(req_addr) / 4;
            e = 1; csw = 0; enw = 0; clr = 0; swap = 0; rdat = 0;
            if (req_valid && req_addr[1:0] == 2'b00 && i <= 6) begin
                case (req_op)
                    2'd0, 2'd1: begin
                        e = 0; rdat = {32'b0, m_read(i)};
                        if (req_op == 2'd0 && i == 6) clr = 1;
                    end
                    2'd2: begin
                        if (i == 3) begin e = 0; csw = 1; end
                        if (i == 4) begin e = 0; enw = 1; end
                    end
                    default: if (i == 0) begin
                        e = 0; rdat = m_owner; swap = (req_cmp == m_owner);
                    end
                endcase
            end
            m_rv = req_valid;
            m_re = req_valid && e;
            m_rd = m_re ? 64'b0 : rdat;
            ev = {src_lock != m_psrc, csw, cur_lock != m_pcur, 2'b00, tx_cfg, rx_cfg};
            if (ev != 0) m_note = ev;
            if (clr) m_slip = 0;
            m_slip = m_slip | src_slip;
            if (bus_rst) begin
                m_st = 0; m_acc = 0;
            end else if (!m_st) begin
                if (ev != 0 && m_owner != IDLE) begin
                    m_st = 1; m_na = m_owner; m_acc = ev;
                end
            end else if (ntf_ready) begin
                if ((m_acc_pend | ev) != 0 && m_owner != IDLE) begin
                    m_na = m_owner; m_acc = m_acc_pend | ev;
                end else m_st = 0;
                m_acc_pend = 0;
            end else m_acc_pend = m_acc_pend | ev;
            if (bus_rst) begin m_owner = IDLE; m_en = 0; m_acc_pend = 0; end
            else begin
                if (swap) m_owner = req_wdata;
                if (enw) m_en = (req_wdata[31:0] != 0);
            end
            if (csw) m_csel = req_wdata[15:0];
            m_pcur = cur_lock; m_psrc = src_lock;
        end
    end
    // m_acc holds the word on the channel; m_acc_pend holds merged events
    logic [6:0] m_acc_pend = '0;

    // per-cycle comparison (R11, R12 and all register state reaching the ports)
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit bad;
            bad = (rsp_valid !== m_rv) || (stream_en !== m_en) || (ntf_valid !== m_st);
            if (m_rv && ((rsp_err !== m_re) || (rsp_rdata !== m_rd))) bad = 1;
            if (m_st && ((ntf_addr !== m_na) || (ntf_word !== {25'b0, m_acc}))) bad = 1;
            n_cmp++;
            if (bad) begin
                n_bad++;
                $display("FAIL R12/R11 per-cycle: act rv=%0b err=%0b rd=%h en=%0b nv=%0b na=%h nw=%h exp rv=%0b err=%0b rd=%h en=%0b nv=%0b na=%h nw=%h",
                    rsp_valid, rsp_err, rsp_rdata, stream_en, ntf_valid, ntf_addr, ntf_word,
                    m_rv, m_re, m_rd, m_en, m_st, m_na, {25'b0, m_acc});
            end
        end
    end

    // ---------------- directed checks ----------------
    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic req(logic [1:0] op, logic [7:0] a, logic [63:0] wd = 0,
                       logic [63:0] cm = 0, logic [10:0] slip = 0);
        @(negedge clk);
        req_valid = 1; req_op = op; req_addr = a; req_wdata = wd; req_cmp = cm;
        src_slip = slip;
        @(negedge clk);
        req_valid = 0; src_slip = 0;
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : wdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        @(negedge clk) rst = 0;
        tick(1);
        // R1 reset state
        chk("R1 ntf idle after reset", {63'b0, ntf_valid}, 0);
        req(2'd0, 8'h00); chk("R1 owner hi", rsp_rdata, 64'hFFFF0000);
        req(2'd0, 8'h04); chk("R1 owner lo", rsp_rdata, 0);
        // R3 illegal accesses
        req(2'd2, 8'h00, 64'h1234); chk("R3 plain owner write err", {63'b0, rsp_err}, 1);
        req(2'd0, 8'h00); chk("R3 owner unchanged", rsp_rdata, 64'hFFFF0000);
        req(2'd0, 8'h09); chk("R3 unaligned err", {63'b0, rsp_err}, 1);
        req(2'd2, 8'h14, 64'hFF); chk("R3 status write err", {63'b0, rsp_err}, 1);
        req(2'd0, 8'h40); chk("R3 out of map err", {63'b0, rsp_err}, 1);
        req(2'd3, 8'h0C, 64'h5, 64'h0); chk("R3 cas off owner err", {63'b0, rsp_err}, 1);
        // R2 failed compare
        req(2'd3, 8'h00, 64'h0123_4567_89AB_CDEF, 64'h0);
        chk("R2 cas returns old", rsp_rdata, IDLE);
        req(2'd0, 8'h00); chk("R2 cas miss no change", rsp_rdata, 64'hFFFF0000);
        // R10 / R8 events with no owner
        @(negedge clk) rx_cfg = 1; @(negedge clk) rx_cfg = 0;
        chk("R11 no request when owner idle", {63'b0, ntf_valid}, 0);
        req(2'd0, 8'h08); chk("R8 R10 rx event word", rsp_rdata, 64'h1);
        @(negedge clk) tx_cfg = 1; @(negedge clk) tx_cfg = 0;
        req(2'd0, 8'h08); chk("R10 replaced by tx", rsp_rdata, 64'h2);
        // R2 successful swap
        req(2'd3, 8'h00, 64'h0123_4567_89AB_CDEF, IDLE);
        chk("R2 cas hit returns old", rsp_rdata, IDLE);
        req(2'd0, 8'h00); chk("R2 owner hi new", rsp_rdata, 64'h01234567);
        req(2'd0, 8'h04); chk("R2 owner lo new", rsp_rdata, 64'h89ABCDEF);
        // R5 clock select + R11 stalled notification
        req(2'd2, 8'h0C, 64'h0000_0A0C);
        chk("R11 request raised", {63'b0, ntf_valid}, 1);
        chk("R5 R11 word accepted bit", {32'b0, ntf_word}, 64'h20);
        chk("R11 request addr", ntf_addr, 64'h0123_4567_89AB_CDEF);
        @(negedge clk) rx_cfg = 1; @(negedge clk) rx_cfg = 0;
        chk("R11 held while stalled", {32'b0, ntf_word}, 64'h20);
        ntf_ready = 1;
        @(negedge clk);
        chk("R11 merged word chained", {32'b0, ntf_word}, 64'h1);
        chk("R11 still valid", {63'b0, ntf_valid}, 1);
        @(negedge clk);
        chk("R11 drained", {63'b0, ntf_valid}, 0);
        req(2'd0, 8'h0C); chk("R5 clock select readback", rsp_rdata, 64'h0A0C);
        // R6 enable
        req(2'd2, 8'h10, 64'h5); chk("R6 enable on", {63'b0, stream_en}, 1);
        req(2'd0, 8'h10); chk("R6 enable reads 1", rsp_rdata, 64'h1);
        req(2'd2, 8'h10, 64'h0); chk("R6 enable off", {63'b0, stream_en}, 0);
        // R7 / R8 status
        @(negedge clk) cur_rate = 8'h02;
        @(negedge clk) cur_lock = 1;
        @(negedge clk);
        req(2'd0, 8'h08); chk("R8 lock change bit", rsp_rdata, 64'h10);
        req(2'd0, 8'h14); chk("R7 status word", rsp_rdata, 64'h0201);
        @(negedge clk) src_lock = 11'h005;
        @(negedge clk);
        req(2'd0, 8'h08); chk("R8 source change bit", rsp_rdata, 64'h40);
        // R9 slip
        @(negedge clk) src_slip = 11'h008; @(negedge clk) src_slip = 0;
        req(2'd1, 8'h18); chk("R9 block read sees slip", rsp_rdata, 64'h0008_0005);
        req(2'd0, 8'h18); chk("R9 quadlet read sees slip", rsp_rdata, 64'h0008_0005);
        req(2'd0, 8'h18, 0, 0, 11'h001); chk("R9 cleared, racing slip not yet shown", rsp_rdata, 64'h0000_0005);
        req(2'd0, 8'h18); chk("R9 racing slip kept", rsp_rdata, 64'h0001_0005);
        // R4 bus reset while streaming and owned
        req(2'd2, 8'h10, 64'h1);
        @(negedge clk) bus_rst = 1; @(negedge clk) bus_rst = 0;
        chk("R4 enable cleared", {63'b0, stream_en}, 0);
        req(2'd0, 8'h00); chk("R4 owner idle", rsp_rdata, 64'hFFFF0000);
        tick(3);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule